// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control store of an audio codec. The host sees four byte-wide ports selected by a 2-bit address. One port holds an index pointer. A second port reads and writes the indirect control register that the pointer selects. The other two are an interrupt status byte and a programmed-I/O data byte. Behind the pointer sit 8-bit control registers. A mode bit in one of them widens the visible set from 16 to 32.

Each indirect register has its own write rule. Some are read-only. Some are reserved. One keeps all bits but one. The sample-format register accepts a write only while a mode-change enable is open. The block also keeps the playback interrupt flag, which the playback engine raises and the host clears. It also produces a one-shot "calibration in progress" indication that the host sees after it opens mode-change enable. The format, interface configuration, pin control and base count registers are driven out to the playback engine. So is a clear pulse for each interrupt acknowledge.

Top module: `codec_regfile`

## Requirements
- R1: Address 0 is the index port, 1 the indirect data port, 2 the status port and 3 the PIO port. The index port resets to 0x40, and its bit 7 is dropped on write and reads as 0. Bit 6 of the index is the mode-change enable (MCE).
- R2: While bit 6 of indirect register 12 is 0, only index bits [3:0] select a register, so index 0x53 reaches register 3. While that bit is 1, index bits [4:0] select one of 32 registers.
- R3: A write to register 12 changes only its bit 6. Register 12 resets to 0x8A.
- R4: Register 8 takes the whole written byte when MCE=1. When MCE=0 and bit 4 of register 24 is 1, bits [7:4] take the write and bits [3:0] are kept. When both are 0, the write has no effect.
- R5: A write to register 9 stores the byte with bit 5 forced to 0.
- R6: Writes to register 11 and to reserved registers 22, 27 and 29 have no effect.
- R7: Any write to the status port clears status bit 0 and irq_o. It also clears bits 6:4 of register 24 and asserts irq_clr_o in the write cycle.
- R8: Take a write to register 24 that finds bit 4 set and writes it as 0. That write clears status bit 0 and irq_o and asserts irq_clr_o. A write that keeps bit 4 set leaves irq_o unchanged.
- R9: An index write that takes MCE from 0 to 1 while bit 3 or bit 4 of register 9 is 1 arms a flag. The next data-port read of register 11 returns bit 5 set and disarms the flag. Reads of other ports or registers leave the flag armed.
- R10: Reset values are 0x88 for registers 2–5 and 18–19, 0x80 for 6–7, 0x08 for 9, 0x8A for 12 and 0xA0 for 25–26. All other registers reset to 0.
- R11: A one-cycle pi_set_i sets status bit 0, irq_o and bit 4 of register 24. When it meets a status-port write in the same cycle, the set wins and bits 6:4 of register 24 end as 3'b001.
- R12: Writes to the PIO port have no effect. The PIO port reads 0x00. The status port reads {7'b0, INT}. No read has a side effect other than R9.
- R13: fmt_o, cfg_o and pin_o carry registers 8, 9 and 10. base_cnt_o carries {register 14, register 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 2 | Direct port select |
| wdata_i | input | 8 | Host write byte |
| pi_set_i | input | 1 | Playback interrupt event from the playback engine |
| rdata_o | output | 8 | Host read byte for addr_i |
| irq_o | output | 1 | Interrupt request |
| irq_clr_o | output | 1 | Interrupt acknowledge pulse to the playback engine |
| fmt_o | output | 8 | Rate and playback format register |
| cfg_o | output | 8 | Interface configuration register |
| pin_o | output | 8 | Pin control register |
| base_cnt_o | output | 16 | Playback base count, upper byte first |

## Verification
The hardest state to reach is the armed calibration flag. Arming it takes an index write with MCE low, then an index write that raises MCE, while register 9 holds bit 3 or bit 4. Every ordinary register access keeps MCE high, so the stimulus drops MCE on purpose. It then raises MCE with both a zero and a non-zero register 9, and reads other ports and registers between arming and the one read that consumes the flag. The format gating needs the same deliberate MCE-low window, together with the partial-write bit held in register 24.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NREG = 32;
  localparam int unsigned IW   = $clog2(NREG);
  localparam int unsigned AW   = 2;

  typedef enum logic [AW-1:0] {
    PORT_IDX  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_STAT = 2'd2,
    PORT_PIO  = 2'd3
  } port_e;

  localparam int unsigned R_FMT    = 8;
  localparam int unsigned R_CFG    = 9;
  localparam int unsigned R_PIN    = 10;
  localparam int unsigned R_INIT   = 11;
  localparam int unsigned R_MODE   = 12;
  localparam int unsigned R_CNT_HI = 14;
  localparam int unsigned R_CNT_LO = 15;
  localparam int unsigned R_FEAT   = 24;

  localparam int unsigned B_MCE   = 6;
  localparam int unsigned B_MODE2 = 6;
  localparam int unsigned B_PMCE  = 4;
  localparam int unsigned B_PI    = 4;
  localparam int unsigned B_CAL   = 5;

  function automatic logic [DW-1:0] rst_val(input int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: rst_val = 8'h88;
      6, 7:               rst_val = 8'h80;
      9:                  rst_val = 8'h08;
      12:                 rst_val = 8'h8A;
      25, 26:             rst_val = 8'hA0;
      default:            rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic locked(input int unsigned i);
    locked = (i == R_INIT) || (i == 22) || (i == 27) || (i == 29);
  endfunction

  // value stored on a data-port write to register i
  function automatic logic [DW-1:0] wr_val(input int unsigned i, input logic [DW-1:0] old,
                                           input logic [DW-1:0] d, input logic mce,
                                           input logic pmce);
    if (locked(i))           wr_val = old;
    else if (i == R_FMT)     wr_val = mce ? d : (pmce ? {d[7:4], old[3:0]} : old);
    else if (i == R_CFG)     wr_val = d & 8'hDF;
    else if (i == R_MODE)    wr_val = {old[7], d[B_MODE2], old[5:0]};
    else                     wr_val = d;
  endfunction
endpackage

// File: rtl/codec_index_port.sv
module codec_index_port
  import codec_regfile_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cal_rd_i,
  input  logic          cal_cfg_i,
  output logic [DW-1:0] idx_o,
  output logic          cal_o
);
  logic [DW-1:0] idx_q;
  logic          cal_q;
  logic          mce_rise;

  assign mce_rise = idx_we_i && !idx_q[B_MCE] && wdata_i[B_MCE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h40;
      cal_q <= 1'b0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i & 8'h7F;
      if (mce_rise && cal_cfg_i) cal_q <= 1'b1;
      else if (cal_rd_i)         cal_q <= 1'b0;
    end
  end

  assign idx_o = idx_q;
  assign cal_o = cal_q;

  p_cal_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_rd_i && !idx_we_i |=> !cal_q);
  p_cal_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_rise && cal_cfg_i |=> cal_q);
  p_idx_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_we_i |=> $stable(idx_q));
endmodule

// File: rtl/codec_ind_file.sv
module codec_ind_file
  import codec_regfile_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] iaddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mce_i,
  input  logic          stat_wr_i,
  input  logic          pi_set_i,
  output logic [DW-1:0] regs_o [NREG],
  output logic          pi_drop_o
);
  logic pmce;
  assign pmce = regs_o[R_FEAT][B_PMCE];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    logic          hit;
    assign hit = we_i && (iaddr_i == IW'(g));
    if (g == R_FEAT) begin : g_feat
      logic [DW-1:0] nxt;
      always_comb begin
        nxt = r_q;
        if (hit)       nxt = wdata_i;
        if (stat_wr_i) nxt = nxt & 8'h8F;
        if (pi_set_i)  nxt[B_PI] = 1'b1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= rst_val(g);
        else         r_q <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  r_q <= rst_val(g);
        else if (hit) r_q <= wr_val(g, r_q, wdata_i, mce_i, pmce);
      end
    end
    assign regs_o[g] = r_q;
  end

  assign pi_drop_o = we_i && (iaddr_i == IW'(R_FEAT)) && regs_o[R_FEAT][B_PI] && !wdata_i[B_PI];

  p_init_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && iaddr_i == IW'(R_INIT) |=> $stable(regs_o[R_INIT]));
  p_mode_bit6_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && iaddr_i == IW'(R_MODE) |=>
      ((regs_o[R_MODE] & 8'hBF) == ($past(regs_o[R_MODE]) & 8'hBF)));
  p_fmt_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && iaddr_i == IW'(R_FMT) && !mce_i |=>
      (regs_o[R_FMT][3:0] == $past(regs_o[R_FMT][3:0])));
  p_cfg_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && iaddr_i == IW'(R_CFG) |=> (regs_o[R_CFG] == ($past(wdata_i) & 8'hDF)));
  p_feat_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !pi_set_i |=> (regs_o[R_FEAT][6:4] == 3'b000));
endmodule

// File: rtl/codec_int_ctrl.sv
module codec_int_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_o
);
  logic int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_q <= 1'b0;
    else if (set_i) int_q <= 1'b1;
    else if (clr_i) int_q <= 1'b0;
  end

  assign int_o = int_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> int_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !int_q);
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regfile_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          pi_set_i,
  output logic [7:0]    rdata_o,
  output logic          irq_o,
  output logic          irq_clr_o,
  output logic [7:0]    fmt_o,
  output logic [7:0]    cfg_o,
  output logic [7:0]    pin_o,
  output logic [15:0]   base_cnt_o
);
  logic [DW-1:0] idx;
  logic          cal;
  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] iaddr;
  logic          mode2;
  logic          pi_drop;
  logic          int_q;
  logic          idx_we, dat_we, stat_we, cal_rd;

  assign idx_we  = wr_i && (addr_i == PORT_IDX);
  assign dat_we  = wr_i && (addr_i == PORT_DATA);
  assign stat_we = wr_i && (addr_i == PORT_STAT);
  assign mode2   = regs[R_MODE][B_MODE2];
  assign iaddr   = mode2 ? idx[IW-1:0] : {1'b0, idx[IW-2:0]};
  assign cal_rd  = rd_i && (addr_i == PORT_DATA) && (iaddr == IW'(R_INIT));

  codec_index_port u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_we_i  (idx_we),
    .wdata_i   (wdata_i),
    .cal_rd_i  (cal_rd),
    .cal_cfg_i (regs[R_CFG][3] | regs[R_CFG][4]),
    .idx_o     (idx),
    .cal_o     (cal)
  );

  codec_ind_file u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dat_we),
    .iaddr_i   (iaddr),
    .wdata_i   (wdata_i),
    .mce_i     (idx[B_MCE]),
    .stat_wr_i (stat_we),
    .pi_set_i  (pi_set_i),
    .regs_o    (regs),
    .pi_drop_o (pi_drop)
  );

  codec_int_ctrl u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pi_set_i),
    .clr_i  (stat_we | pi_drop),
    .int_o  (int_q)
  );

  always_comb begin
    case (addr_i)
      PORT_IDX:  rdata_o = idx;
      PORT_DATA: rdata_o = regs[iaddr] | ((iaddr == IW'(R_INIT) && cal) ? 8'h20 : 8'h00);
      PORT_STAT: rdata_o = {7'b0, int_q};
      default:   rdata_o = 8'h00;
    endcase
  end

  assign irq_o      = int_q;
  assign irq_clr_o  = stat_we | pi_drop;
  assign fmt_o      = regs[R_FMT];
  assign cfg_o      = regs[R_CFG];
  assign pin_o      = regs[R_PIN];
  assign base_cnt_o = {regs[R_CNT_HI], regs[R_CNT_LO]};

  p_pio_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == PORT_PIO && !pi_set_i |=> $stable(irq_o) && $stable(fmt_o) && $stable(cfg_o));
  p_irq_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o && !pi_set_i |=> !irq_o);
endmodule

// File: tb/codec_regfile_tb.sv
`timescale 1ns/1ps
module codec_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, pi_set = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, fmt, cfg, pin;
  logic [15:0] base_cnt;
  logic irq, irq_clr;
  logic clr_seen;
  int tot = 0, bad = 0;

  always #2.5 clk = ~clk;

  codec_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_en), .rd_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .pi_set_i(pi_set), .rdata_o(rdata), .irq_o(irq),
    .irq_clr_o(irq_clr), .fmt_o(fmt), .cfg_o(cfg), .pin_o(pin), .base_cnt_o(base_cnt)
  );

  function automatic logic [7:0] pat(input int i);
    pat = 8'((i * 37 + 8'h5A) & 8'hFF);
  endfunction

  function automatic logic [7:0] exp_rst(input int i);
    if ((i >= 2 && i <= 5) || i == 18 || i == 19) exp_rst = 8'h88;
    else if (i == 6 || i == 7) exp_rst = 8'h80;
    else if (i == 9) exp_rst = 8'h08;
    else if (i == 12) exp_rst = 8'h8A;
    else if (i == 25 || i == 26) exp_rst = 8'hA0;
    else exp_rst = 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1 clr_seen = irq_clr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wreg(input int i, input logic [7:0] d);
    wr(2'd0, 8'h40 | 8'(i));
    wr(2'd1, d);
  endtask

  task automatic rreg(input int i, output logic [7:0] d);
    wr(2'd0, 8'h40 | 8'(i));
    rd(2'd1, d);
  endtask

  task automatic pi_pulse();
    @(negedge clk);
    pi_set = 1'b1;
    @(negedge clk);
    pi_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    tot++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd0, v); check("R1 index reset", v, 8'h40);
    check("R13 fmt reset", fmt, 8'h00);
    check("R13 cfg reset", cfg, 8'h08);
    check("R11 irq reset", irq, 0);
    for (int i = 0; i < 16; i++) begin
      rreg(i, v); check("R10 reset mode1", v, exp_rst(i));
    end
    // R3: only bit 6 of register 12 takes the write
    wreg(12, 8'hFF & 8'h40 | 8'h05); rreg(12, v); check("R3 mode reg", v, 8'hCA);
    for (int i = 0; i < 32; i++) begin
      rreg(i, v); check("R10 reset mode2", v, i == 12 ? 8'hCA : exp_rst(i));
    end

    // full sweep of writes in 32-register mode, MCE held set
    for (int i = 0; i < 32; i++) if (i != 12) wreg(i, pat(i));
    for (int i = 0; i < 32; i++) begin
      if (i == 11 || i == 22 || i == 27 || i == 29) e = exp_rst(i);  // R6
      else if (i == 9) e = pat(i) & 8'hDF;                             // R5
      else if (i == 12) e = 8'hCA;
      else e = pat(i);                                                 // R4 with MCE
      rreg(i, v); check("R4 R5 R6 sweep", v, e);
    end
    check("R13 fmt_o", fmt, pat(8));
    check("R13 cfg_o", cfg, pat(9) & 8'hDF);
    check("R13 pin_o", pin, pat(10));
    check("R13 base_cnt_o", base_cnt, {pat(14), pat(15)});

    // R2: 16-register mode aliases index bit 4
    wreg(12, 8'h00);
    wr(2'd0, 8'h53); wr(2'd1, 8'h77); rd(2'd1, v); check("R2 alias write", v, 8'h77);
    wr(2'd0, 8'h5C); rd(2'd1, v); check("R2 alias reg12", v, 8'h8A);
    wr(2'd1, 8'h40);
    rreg(3, v);  check("R2 reg3", v, 8'h77);
    rreg(19, v); check("R2 reg19 untouched", v, pat(19));

    // R4 format gating
    wreg(9, 8'h00);
    wreg(24, 8'h00);
    wreg(8, 8'h3C);
    wr(2'd0, 8'h08); wr(2'd1, 8'hFF); rd(2'd1, v); check("R4 discard", v, 8'h3C);
    wr(2'd0, 8'h18); wr(2'd1, 8'h10);
    wr(2'd0, 8'h08); wr(2'd1, 8'hA5); rd(2'd1, v); check("R4 partial", v, 8'hAC);
    check("R13 fmt partial", fmt, 8'hAC);
    wr(2'd0, 8'h48);
    rreg(11, v); check("R9 no arm cfg zero", v, 8'h00);

    // R9 calibration flag
    wreg(9, 8'h10);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R9 first read", v, 8'h20);
    rd(2'd1, v); check("R9 second read", v, 8'h00);
    wreg(9, 8'h08);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd2, v); rd(2'd0, v); check("R1 index read", v, 8'h4B);
    wr(2'd0, 8'h4A); rd(2'd1, v); check("R9 other reg", v, pat(10));
    wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R9 still armed", v, 8'h20);
    rd(2'd1, v); check("R9 disarmed", v, 8'h00);

    // R11 / R7 interrupt set and status clear
    wreg(24, 8'h7F);
    check("R8 no drop irq", irq, 0);
    pi_pulse();
    check("R11 irq set", irq, 1);
    rd(2'd2, v); check("R11 status", v, 8'h01);
    wr(2'd2, 8'h00);
    check("R7 clr pulse", clr_seen, 1);
    check("R7 irq low", irq, 0);
    rd(2'd2, v); check("R7 status", v, 8'h00);
    rreg(24, v); check("R7 reg24 bits", v, 8'h0F);

    // R8 clearing PI through register 24
    pi_pulse();
    rreg(24, v); check("R11 reg24 PI", v, 8'h1F);
    wreg(24, 8'h1F); check("R8 keep PI", irq, 1);
    wreg(24, 8'h0F);
    check("R8 drop pulse", clr_seen, 1);
    check("R8 drop irq", irq, 0);

    // R11 set wins over status clear
    @(negedge clk);
    addr = 2'd2; wr_en = 1'b1; pi_set = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pi_set = 1'b0;
    check("R11 set wins", irq, 1);
    rreg(24, v); check("R11 set wins reg24", v, 8'h1F);
    wr(2'd2, 8'h55); check("R7 irq low again", irq, 0);

    // R12 PIO and read side effects
    wr(2'd3, 8'hAB);
    rd(2'd3, v); check("R12 pio read", v, 8'h00);
    rd(2'd2, v); rd(2'd2, v); check("R12 status stable", v, 8'h00);
    rd(2'd0, v); check("R12 index kept", v, 8'h58);
    check("R12 fmt kept", fmt, 8'hAC);

    finish_run();
  end
endmodule